// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns one indexed memory operand into a 16-bit effective address. The caller has already split the operand into fields: an addressing mode, a base register selector, an offset and its width, a step amount and an accumulator selector. The block receives the current register contents on its inputs. On a start pulse it forms the address from one of four base registers (X, Y, SP, PC) plus a sign-extended constant, an unsigned accumulator value, or an automatic step of 1 to 8.

The two modes that change the base register also report the new base value and a one-cycle write-back strobe, so the register file can update the pointer. In the two memory-indirect modes the sum of base and offset is a pointer to a stored address. The block then reads two bytes through a simple request/valid port. The high byte comes from the pointer and the low byte from the pointer plus one. The pair of bytes is the final address. Every result comes with a one-cycle `done` pulse. A step amount outside 1 to 8 finishes at once with an error flag.

Top module: `idx_ea_gen`

## Requirements
- R1: In mode 0 (constant offset) `ea` = base + sign-extended `offset`. `off_size` 0 takes `offset[4:0]`, 1 takes `offset[8:0]`, and 2 or 3 take all 16 bits.
- R2: `base_sel` picks the base register: 0 is X, 1 is Y, 2 is SP, 3 is PC.
- R3: Mode 1 (pre-decrement) and mode 2 (pre-increment) give `ea` = base − `step` or base + `step`. `wb_value` equals that same `ea`.
- R4: Mode 3 (post-decrement) and mode 4 (post-increment) give `ea` = the old base. `wb_value` = base − `step` or base + `step`.
- R5: In mode 5 (accumulator offset) `ea` = base + the zero-extended accumulator. `acc_sel` 0 is A, 1 is B, and 2 or 3 is D = {A,B}.
- R6: Mode 6 (indirect, 16-bit constant) and mode 7 (indirect, D) form a pointer = base + offset. The block reads the high byte at the pointer, then the low byte at the pointer + 1, and `ea` = {high, low}.
- R7: All address sums, steps and the pointer + 1 wrap modulo 2^16.
- R8: `wb_en` is high for exactly the one `done` cycle of modes 1 to 4 and never otherwise. `wb_sel` then repeats `base_sel`.
- R9: In modes 1 to 4, a `step` of 0 or above 8 gives `done` with `err` = 1 the cycle after start, with no write-back.
- R10: After reset `done`, `err`, `wb_en` and `mem_req` are 0. Direct modes finish the cycle after start. `mem_addr` holds steady while `mem_req` waits for `mem_valid`. A start that arrives during an indirect read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one address computation |
| mode | input | 3 | Addressing mode, 0..7 |
| base_sel | input | 2 | Base register selector |
| off_size | input | 2 | Constant offset width selector |
| offset | input | 16 | Raw constant offset |
| step | input | 4 | Auto-modify amount |
| acc_sel | input | 2 | Accumulator offset selector |
| reg_x | input | 16 | X register value |
| reg_y | input | 16 | Y register value |
| reg_sp | input | 16 | Stack pointer value |
| reg_pc | input | 16 | Program counter value |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 16 | Indirect read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | Result valid, one cycle |
| ea | output | 16 | Effective address |
| err | output | 1 | Illegal step amount |
| wb_en | output | 1 | Base write-back strobe |
| wb_sel | output | 2 | Base register to write back |
| wb_value | output | 16 | Updated base value |

## Verification
The bench targets these corner cases:

- **Offset extension:** short offsets whose sign bit is set while the upper raw bits hold junk. A design that takes the wrong bits or zero-extends returns an address off by a power of two.
- **Carry across the 16-bit edge:** steps and pointers that run past `$FFFF` or below `$0000`. This includes a pointer at `$FFFF`, whose low byte must come from `$0000`.
- **Pre versus post modes:** the bench checks that pre and post modes hand back different values on `ea` and `wb_value`. Swapping them would go unnoticed if only one output were checked.
- **Read timing and ordering:** indirect reads run with several memory latencies and with a stray start in flight. A design that swaps the bytes, loses the request address or restarts on that start shows a wrong address or an extra `done`.
- **Illegal steps:** the limit values 0 and 9 must flag `err` with no write-back.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    typedef enum logic [2:0] {
        M_CONST     = 3'd0,
        M_PREDEC    = 3'd1,
        M_PREINC    = 3'd2,
        M_POSTDEC   = 3'd3,
        M_POSTINC   = 3'd4,
        M_ACC       = 3'd5,
        M_IND_CONST = 3'd6,
        M_IND_D     = 3'd7
    } ea_mode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RD_HI = 2'd1,
        S_RD_LO = 2'd2
    } ea_state_e;

endpackage

// File: rtl/idx_base_mux.sv
module idx_base_mux #(
    parameter int AW    = 16,
    parameter int NBASE = 4,
    localparam int SEL_W = $clog2(NBASE)
) (
    input  logic [NBASE-1:0][AW-1:0] regs,
    input  logic [SEL_W-1:0]         sel,
    output logic [AW-1:0]            base
);
    // One-hot select across the register set.
    logic [NBASE-1:0][AW-1:0] masked;

    for (genvar g = 0; g < NBASE; g++) begin : g_mask
        assign masked[g] = (sel == SEL_W'(g)) ? regs[g] : '0;
    end

    always_comb begin
        base = '0;
        for (int i = 0; i < NBASE; i++) base = base | masked[i];
    end
endmodule

// File: rtl/idx_offset_unit.sv
module idx_offset_unit #(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int SHORT_W = 5,
    parameter int MID_W   = 9
) (
    input  logic [1:0]    size_sel,
    input  logic [AW-1:0] raw,
    input  logic [1:0]    acc_sel,
    input  logic [DW-1:0] acc_a,
    input  logic [DW-1:0] acc_b,
    output logic [AW-1:0] const_off,
    output logic [AW-1:0] acc_off,
    output logic [AW-1:0] d_off
);
    localparam int NW = 3;
    localparam int WIDTHS [NW] = '{SHORT_W, MID_W, AW};

    logic [NW-1:0][AW-1:0] ext;

    // Sign extension for each supported constant width.
    for (genvar g = 0; g < NW; g++) begin : g_ext
        if (WIDTHS[g] < AW) begin : g_short
            assign ext[g] = {{(AW-WIDTHS[g]){raw[WIDTHS[g]-1]}}, raw[WIDTHS[g]-1:0]};
        end else begin : g_full
            assign ext[g] = raw;
        end
    end

    always_comb begin
        case (size_sel)
            2'd0:    const_off = ext[0];
            2'd1:    const_off = ext[1];
            default: const_off = ext[2];
        endcase
    end

    assign d_off = AW'({acc_a, acc_b});

    always_comb begin
        case (acc_sel)
            2'd0:    acc_off = AW'(acc_a);
            2'd1:    acc_off = AW'(acc_b);
            default: acc_off = d_off;
        endcase
    end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
    import idx_ea_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int STEP_W   = 4,
    parameter int MAX_STEP = 8,
    parameter int SHORT_W  = 5,
    parameter int MID_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [1:0]        base_sel,
    input  logic [1:0]        off_size,
    input  logic [AW-1:0]     offset,
    input  logic [STEP_W-1:0] step,
    input  logic [1:0]        acc_sel,
    input  logic [AW-1:0]     reg_x,
    input  logic [AW-1:0]     reg_y,
    input  logic [AW-1:0]     reg_sp,
    input  logic [AW-1:0]     reg_pc,
    input  logic [DW-1:0]     acc_a,
    input  logic [DW-1:0]     acc_b,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_valid,
    input  logic [DW-1:0]     mem_rdata,
    output logic              done,
    output logic [AW-1:0]     ea,
    output logic              err,
    output logic              wb_en,
    output logic [1:0]        wb_sel,
    output logic [AW-1:0]     wb_value
);
    localparam int NBASE = 4;
    localparam logic [STEP_W-1:0] STEP_LIM = STEP_W'(MAX_STEP);

    typedef struct packed {
        ea_state_e     state;
        logic [AW-1:0] ea;
        logic          done;
        logic          err;
        logic          wb_en;
        logic [1:0]    wb_sel;
        logic [AW-1:0] wb_value;
        logic [AW-1:0] ptr;
        logic [DW-1:0] hi;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [AW-1:0] base, const_off, acc_off, d_off;
    logic [AW-1:0] step_ext, base_up, base_dn;
    logic          step_ok;
    ea_mode_e      mode_e;

    idx_base_mux #(.AW(AW), .NBASE(NBASE)) i_base_mux (
        .regs (/* index 0 is X */ {reg_pc, reg_sp, reg_y, reg_x}),
        .sel  (base_sel),
        .base (base)
    );

    idx_offset_unit #(.AW(AW), .DW(DW), .SHORT_W(SHORT_W), .MID_W(MID_W)) i_offset_unit (
        .size_sel  (off_size),
        .raw       (offset),
        .acc_sel   (acc_sel),
        .acc_a     (acc_a),
        .acc_b     (acc_b),
        .const_off (const_off),
        .acc_off   (acc_off),
        .d_off     (d_off)
    );

    assign mode_e   = ea_mode_e'(mode);
    assign step_ext = AW'(step);
    assign base_up  = base + step_ext;
    assign base_dn  = base - step_ext;
    assign step_ok  = (step != '0) && (step <= STEP_LIM);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.err   = 1'b0;
        ctl_d.wb_en = 1'b0;
        case (ctl_q.state)
            S_IDLE: begin
                if (start) begin
                    ctl_d.wb_sel = base_sel;
                    case (mode_e)
                        M_CONST: begin
                            ctl_d.ea   = base + const_off;
                            ctl_d.done = 1'b1;
                        end
                        M_ACC: begin
                            ctl_d.ea   = base + acc_off;
                            ctl_d.done = 1'b1;
                        end
                        M_PREDEC, M_PREINC, M_POSTDEC, M_POSTINC: begin
                            ctl_d.done = 1'b1;
                            if (!step_ok) begin
                                ctl_d.err = 1'b1;
                            end else begin
                                ctl_d.wb_en = 1'b1;
                                case (mode_e)
                                    M_PREDEC: begin
                                        ctl_d.ea = base_dn; ctl_d.wb_value = base_dn;
                                    end
                                    M_PREINC: begin
                                        ctl_d.ea = base_up; ctl_d.wb_value = base_up;
                                    end
                                    M_POSTDEC: begin
                                        ctl_d.ea = base; ctl_d.wb_value = base_dn;
                                    end
                                    default: begin
                                        ctl_d.ea = base; ctl_d.wb_value = base_up;
                                    end
                                endcase
                            end
                        end
                        M_IND_CONST: begin
                            ctl_d.ptr   = base + offset;
                            ctl_d.state = S_RD_HI;
                        end
                        default: begin
                            ctl_d.ptr   = base + d_off;
                            ctl_d.state = S_RD_HI;
                        end
                    endcase
                end
            end
            S_RD_HI: begin
                if (mem_valid) begin
                    ctl_d.hi    = mem_rdata;
                    ctl_d.state = S_RD_LO;
                end
            end
            default: begin
                if (mem_valid) begin
                    ctl_d.ea    = AW'({ctl_q.hi, mem_rdata});
                    ctl_d.done  = 1'b1;
                    ctl_d.state = S_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: S_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign mem_req  = (ctl_q.state != S_IDLE);
    assign mem_addr = (ctl_q.state == S_RD_LO) ? ctl_q.ptr + AW'(1) : ctl_q.ptr;
    assign done     = ctl_q.done;
    assign ea       = ctl_q.ea;
    assign err      = ctl_q.err;
    assign wb_en    = ctl_q.wb_en;
    assign wb_sel   = ctl_q.wb_sel;
    assign wb_value = ctl_q.wb_value;

    // R8
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && !err));

    // R9
    err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_req && !wb_en));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R10
    direct_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && mode < 3'd6) |=> done);

    // R7
    next_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == S_RD_HI && mem_valid) |=> (mem_addr == AW'($past(mem_addr) + AW'(1))));

    // R6
    lo_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == S_RD_LO && mem_valid) |=> (done && !wb_en && !mem_req));
endmodule

// File: tb/test_idx_ea_gen.sv
module test_idx_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  base_sel = '0, off_size = '0, acc_sel = '0;
    logic [15:0] offset = '0;
    logic [3:0]  step = '0;
    logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3000, reg_pc = 16'h4000;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic        mem_req, mem_valid = 1'b0;
    logic [15:0] mem_addr, ea, wb_value;
    logic [7:0]  mem_rdata = '0;
    logic        done, err, wb_en;
    logic [1:0]  wb_sel;

    int n_chk = 0, n_fail = 0, cyc = 0, lat = 0, mcnt = 0;
    int rd_addr[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_ea_gen i_idx_ea_gen (
        .clk, .rst_n, .start, .mode, .base_sel, .off_size, .offset, .step, .acc_sel,
        .reg_x, .reg_y, .reg_sp, .reg_pc, .acc_a, .acc_b,
        .mem_req, .mem_addr, .mem_valid, .mem_rdata,
        .done, .ea, .err, .wb_en, .wb_sel, .wb_value
    );

    function automatic logic [7:0] mem_byte(int a);
        return 8'((a & 255) ^ ((a >> 8) & 255)) + 8'h3C;
    endfunction

    // Behavioural memory with a programmable wait before each byte.
    always @(negedge clk) begin
        if (mem_valid) begin
            mem_valid <= 1'b0;
        end else if (mem_req) begin
            if (mcnt == lat) begin
                mem_valid <= 1'b1;
                mem_rdata <= mem_byte(int'(mem_addr));
                rd_addr.push_back(int'(mem_addr));
                mcnt = 0;
            end else begin
                mcnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic finish_sim;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int base_of(int s);
        case (s)
            0: return int'(reg_x);
            1: return int'(reg_y);
            2: return int'(reg_sp);
            default: return int'(reg_pc);
        endcase
    endfunction

    function automatic int sext(int v, int w);
        int m = v & ((1 << w) - 1);
        if (m >= (1 << (w - 1))) m -= (1 << w);
        return m;
    endfunction

    // One operation: reference values from the requirements, compared every cycle.
    task automatic run_op(input int md, input int bs, input int sz, input int off,
                          input int st, input int as, input int l, input bit poke,
                          input string req);
        int b = base_of(bs);
        int e_ea = 0, e_wb = 0, e_cyc = 1, ptr = 0, dval;
        bit e_wben = 0, e_err = 0, ind = 0;
        dval = int'(acc_a) * 256 + int'(acc_b);
        case (md)
            0: e_ea = b + sext(off, sz == 0 ? 5 : sz == 1 ? 9 : 16);
            5: e_ea = b + (as == 0 ? int'(acc_a) : as == 1 ? int'(acc_b) : dval);
            1, 2, 3, 4: begin
                if (st < 1 || st > 8) e_err = 1;
                else begin
                    e_wben = 1;
                    e_wb = (md == 1 || md == 3) ? b - st : b + st;
                    e_ea = (md <= 2) ? e_wb : b;
                end
            end
            default: begin
                ind = 1;
                ptr = (b + (md == 6 ? off : dval)) & 16'hFFFF;
                e_ea = int'(mem_byte(ptr)) * 256 + int'(mem_byte((ptr + 1) & 16'hFFFF));
                e_cyc = 4 + 2 * l;
            end
        endcase
        e_ea &= 16'hFFFF; e_wb &= 16'hFFFF;
        lat = l; mcnt = 0; rd_addr.delete();
        mode = 3'(md); base_sel = 2'(bs); off_size = 2'(sz); offset = 16'(off);
        step = 4'(st); acc_sel = 2'(as); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= e_cyc; c++) begin
            if (poke && c == 2) begin mode = 3'd0; start = 1'b1; end
            else start = 1'b0;
            if (c < e_cyc) begin
                chk(done == 1'b0, "R10", "early done", int'(done), 0);
                chk(wb_en == 1'b0, "R8", "early wb_en", int'(wb_en), 0);
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(done == 1'b1, "R10", "done at expected cycle", int'(done), 1);
        chk(err == e_err, e_err ? "R9" : req, "err", int'(err), int'(e_err));
        chk(wb_en == e_wben, "R8", "wb_en", int'(wb_en), int'(e_wben));
        if (!e_err) chk(ea == 16'(e_ea), req, "ea", int'(ea), e_ea);
        if (e_wben) begin
            chk(wb_value == 16'(e_wb), req, "wb_value", int'(wb_value), e_wb);
            chk(wb_sel == 2'(bs), "R8", "wb_sel", int'(wb_sel), bs);
        end
        if (e_err) chk(mem_req == 1'b0 && rd_addr.size() == 0, "R9", "read on error", int'(mem_req), 0);
        if (ind) begin
            chk(rd_addr.size() == 2, "R6", "byte reads", rd_addr.size(), 2);
            if (rd_addr.size() == 2) begin
                chk(rd_addr[0] == ptr, "R6", "high byte addr", rd_addr[0], ptr);
                chk(rd_addr[1] == ((ptr + 1) & 16'hFFFF), "R7", "low byte addr", rd_addr[1], (ptr + 1) & 16'hFFFF);
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "single done", int'(done), 0);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(done == 0 && err == 0 && wb_en == 0 && mem_req == 0, "R10", "reset outputs",
            int'({done, err, wb_en, mem_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 widths, junk above the field
        run_op(0, 0, 0, 16'hFF10, 0, 0, 0, 0, "R1");
        run_op(0, 1, 1, 16'hFE05, 0, 0, 0, 0, "R1");
        run_op(0, 2, 2, 16'h8001, 0, 0, 0, 0, "R1");
        run_op(0, 3, 3, 16'h0123, 0, 0, 0, 0, "R2");
        // R7 wrap below zero through a short offset
        reg_pc = 16'h0000;
        run_op(0, 3, 1, 16'h01FF, 0, 0, 0, 0, "R7");
        // R2 each base
        for (int s = 0; s < 4; s++) run_op(0, s, 2, 16'h0010, 0, 0, 0, 0, "R2");
        // R3 pre modes
        reg_sp = 16'h0004;
        run_op(1, 2, 0, 0, 8, 0, 0, 0, "R3");
        run_op(2, 0, 0, 0, 1, 0, 0, 0, "R3");
        // R4 post modes
        run_op(3, 1, 0, 0, 3, 0, 0, 0, "R4");
        reg_y = 16'hFFFE;
        run_op(4, 1, 0, 0, 8, 0, 0, 0, "R4");
        // R9 illegal steps
        run_op(2, 0, 0, 0, 0, 0, 0, 0, "R9");
        run_op(3, 0, 0, 0, 9, 0, 0, 0, "R9");
        run_op(1, 0, 0, 0, 15, 0, 0, 0, "R9");
        // R5 accumulator offsets
        acc_a = 8'h80; acc_b = 8'hF1;
        run_op(5, 0, 0, 0, 0, 0, 0, 0, "R5");
        run_op(5, 0, 0, 0, 0, 1, 0, 0, "R5");
        run_op(5, 2, 0, 0, 0, 2, 0, 0, "R5");
        run_op(5, 3, 0, 0, 0, 3, 0, 0, "R5");
        // R6 indirect with several latencies
        run_op(6, 0, 0, 16'h0234, 0, 0, 0, 0, "R6");
        run_op(6, 1, 0, 16'h0100, 0, 0, 2, 0, "R6");
        reg_x = 16'hFFF0;
        run_op(6, 0, 0, 16'h000F, 0, 0, 1, 0, "R7");
        run_op(7, 2, 0, 0, 0, 0, 3, 1, "R6");
        run_op(7, 0, 0, 0, 0, 0, 0, 1, "R10");
        finish_sim();
    end
endmodule